// File: doc/BRIEF.md
# Sparse Token-Chained Super-Pixel Column Readout

This block reads one column of a hybrid pixel detector. The column is divided into `N_SP` super-pixels. Each super-pixel serves a 4x4 group of sixteen pixels and shares one set of digital logic among them. Each pixel reports a hit flag and a 4-bit time-over-threshold (TOT) value. A super-pixel stores these until its turn to read out comes. The super-pixels share one 8-bit column bus, which has a byte strobe. Bus ownership is passed along a daisy-chained token.

A column scan begins when `col_start` is pulsed. That pulse injects the token at super-pixel 0. A super-pixel that holds hits takes the bus and emits a compact packet:
- a header byte carrying its position in the column;
- a two-byte hit map;
- the TOT nibbles of the hit pixels only, packed two per byte.

It then clears its store and hands the token on. A super-pixel with nothing stored hands the token on at once and uses no bus cycle. When the token leaves the final super-pixel, a one-cycle end-of-column pulse marks the end of the scan. Only hit data ever reaches the bus.

Top module: `col_token_readout`

## Requirements
- R1: While reset is asserted and right after it, `bus_valid`, `bus_data` and `col_end` are all 0.
- R2: A super-pixel with an empty store forwards the token in the same cycle it receives it and drives no bus cycle. A scan of an all-empty column raises `col_end` in the same cycle as `col_start`.
- R3: The first byte of a packet is the header, equal to the super-pixel's index in the column. Index 0 is the super-pixel where the token enters.
- R4: The header is followed by the hit map: first bits 15..8, then bits 7..0. Bit i is 1 when pixel i (i = 4*row + col) holds a hit.
- R5: The hit map is followed by the TOT values of the hit pixels in ascending pixel order. The lower-indexed pixel of each pair goes in bits 7:4 and the next one in bits 3:0. When the hit count is odd, the last byte has bits 3:0 = 0.
- R6: Packets appear in ascending super-pixel order, and only one super-pixel drives the bus in any cycle. The next non-empty super-pixel drives its header in the cycle right after the previous packet's last byte.
- R7: `col_end` is high for exactly the cycle in which the token leaves the last super-pixel. A scan that emits B bytes in total ends B cycles after the `col_start` cycle.
- R8: Once a super-pixel has sent its packet, its stored hits are cleared. A following scan with no new hits emits nothing from it.
- R9: Hits that arrive in the cycle the token reaches a super-pixel, or while it is sending, are left out of the current packet. They are sent at its next turn.
- R10: A pixel that already holds an unread hit ignores later hits. The TOT value of its first hit is the one sent.
- R11: `bus_data` is 0 in every cycle where `bus_valid` is low.
- R12: A super-pixel that receives the token in a cycle drives its header in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_start | input | 1 | One-cycle pulse that injects the token at super-pixel 0 |
| pix_hit | input | N_SP*16 | Per-pixel hit flags; bit 16*s+i is pixel i of super-pixel s |
| pix_tot | input | N_SP*64 | Per-pixel TOT; bits 64*s+4*i+3 : 64*s+4*i belong to pixel i of super-pixel s |
| bus_data | output | 8 | Column bus byte |
| bus_valid | output | 1 | Byte strobe for `bus_data` |
| col_end | output | 1 | End-of-column pulse |

## Verification
The checker watches every cycle for the following:
- more than one super-pixel driving the bus at the same time;
- a non-zero idle bus;
- a packet whose first byte is not its owner's header;
- a packet that ends without the token moving on in its last cycle.

Other behaviours only show in the bench's scenarios, which compare every byte against a model of the store:
- the content of the hit map and of the packed TOT nibbles;
- the zero padding;
- clearing after readout;
- the first-hit-wins rule;
- the holding of hits that arrive during readout;
- the exact cycle count from `col_start` to `col_end`.

// File: rtl/col_pkg.sv
package col_pkg;
    localparam int PIX_PER_SP = 16;
    localparam int TOT_W      = 4;
    localparam int BUS_W      = 8;
    localparam int PIX_IDX_W  = $clog2(PIX_PER_SP);
    localparam int SP_TOT_W   = PIX_PER_SP * TOT_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_MAP_HI,
        ST_MAP_LO,
        ST_TOT
    } pk_state_e;
endpackage

// File: rtl/sp_hit_store.sv
module sp_hit_store
    import col_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIX_PER_SP-1:0] hit_i,
    input  logic [SP_TOT_W-1:0]   tot_i,
    input  logic                  take_i,
    output logic [PIX_PER_SP-1:0] mask_o,
    output logic [SP_TOT_W-1:0]   tot_o
);
    typedef struct packed {
        logic [PIX_PER_SP-1:0] mask;
        logic [SP_TOT_W-1:0]   tot;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) st_d.mask = '0;
        for (int i = 0; i < PIX_PER_SP; i++) begin
            if (hit_i[i] && !st_d.mask[i]) begin
                st_d.mask[i] = 1'b1;
                st_d.tot[i*TOT_W +: TOT_W] = tot_i[i*TOT_W +: TOT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign tot_o  = st_q.tot;
endmodule

// File: rtl/sp_packer.sv
module sp_packer
    import col_pkg::*;
#(
    parameter int SP_ADDR = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tok_i,
    input  logic [PIX_PER_SP-1:0] mask_i,
    input  logic [SP_TOT_W-1:0]   tot_i,
    output logic                  take_o,
    output logic                  tok_o,
    output logic                  drv_o,
    output logic [BUS_W-1:0]      byte_o
);
    localparam logic [BUS_W-1:0] HDR_BYTE = BUS_W'(SP_ADDR);

    typedef struct packed {
        pk_state_e             state;
        logic [PIX_PER_SP-1:0] shmask;
        logic [PIX_PER_SP-1:0] rem;
        logic [SP_TOT_W-1:0]   shtot;
    } pk_t;

    pk_t pk_d, pk_q;
    logic [PIX_IDX_W-1:0] idx0, idx1;
    logic f0, f1, f2;

    always_comb begin
        f0 = 1'b0; f1 = 1'b0; f2 = 1'b0;
        idx0 = '0; idx1 = '0;
        for (int i = 0; i < PIX_PER_SP; i++) begin
            if (pk_q.rem[i]) begin
                if (!f0) begin
                    f0 = 1'b1; idx0 = i[PIX_IDX_W-1:0];
                end else if (!f1) begin
                    f1 = 1'b1; idx1 = i[PIX_IDX_W-1:0];
                end else begin
                    f2 = 1'b1;
                end
            end
        end

        take_o = (pk_q.state == ST_IDLE) && tok_i && (mask_i != '0);
        tok_o  = ((pk_q.state == ST_IDLE) && tok_i && (mask_i == '0)) ||
                 ((pk_q.state == ST_TOT) && !f2);
        drv_o  = (pk_q.state != ST_IDLE);

        unique case (pk_q.state)
            ST_HDR:    byte_o = HDR_BYTE;
            ST_MAP_HI: byte_o = pk_q.shmask[15:8];
            ST_MAP_LO: byte_o = pk_q.shmask[7:0];
            ST_TOT:    byte_o = {pk_q.shtot[idx0*TOT_W +: TOT_W],
                                 f1 ? pk_q.shtot[idx1*TOT_W +: TOT_W] : {TOT_W{1'b0}}};
            default:   byte_o = '0;
        endcase

        pk_d = pk_q;
        unique case (pk_q.state)
            ST_IDLE: if (take_o) begin
                pk_d.state  = ST_HDR;
                pk_d.shmask = mask_i;
                pk_d.rem    = mask_i;
                pk_d.shtot  = tot_i;
            end
            ST_HDR:    pk_d.state = ST_MAP_HI;
            ST_MAP_HI: pk_d.state = ST_MAP_LO;
            ST_MAP_LO: pk_d.state = ST_TOT;
            ST_TOT: begin
                pk_d.rem[idx0] = 1'b0;
                if (f1) pk_d.rem[idx1] = 1'b0;
                if (!f2) pk_d.state = ST_IDLE;
            end
            default: pk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end
endmodule

// File: rtl/col_token_readout.sv
module col_token_readout
    import col_pkg::*;
#(
    parameter int N_SP = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       col_start,
    input  logic [N_SP*PIX_PER_SP-1:0] pix_hit,
    input  logic [N_SP*SP_TOT_W-1:0]   pix_tot,
    output logic [BUS_W-1:0]           bus_data,
    output logic                       bus_valid,
    output logic                       col_end
);
    logic [N_SP:0]         tok_vec;
    logic [N_SP-1:0]       drv_vec;
    logic [N_SP-1:0]       take_vec;
    logic [N_SP*BUS_W-1:0] byte_vec;

    assign tok_vec[0] = col_start;

    for (genvar s = 0; s < N_SP; s++) begin : g_sp
        logic [PIX_PER_SP-1:0] mask;
        logic [SP_TOT_W-1:0]   tot;

        sp_hit_store u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (pix_hit[s*PIX_PER_SP +: PIX_PER_SP]),
            .tot_i  (pix_tot[s*SP_TOT_W +: SP_TOT_W]),
            .take_i (take_vec[s]),
            .mask_o (mask),
            .tot_o  (tot)
        );

        sp_packer #(.SP_ADDR(s)) u_pack (
            .clk    (clk),
            .rst_n  (rst_n),
            .tok_i  (tok_vec[s]),
            .mask_i (mask),
            .tot_i  (tot),
            .take_o (take_vec[s]),
            .tok_o  (tok_vec[s+1]),
            .drv_o  (drv_vec[s]),
            .byte_o (byte_vec[s*BUS_W +: BUS_W])
        );
    end

    always_comb begin
        bus_data = '0;
        for (int s = 0; s < N_SP; s++) begin
            if (drv_vec[s]) bus_data = bus_data | byte_vec[s*BUS_W +: BUS_W];
        end
    end

    assign bus_valid = |drv_vec;
    assign col_end   = tok_vec[N_SP];
endmodule

// File: rtl/col_token_readout_chk.sv
module col_token_readout_chk
    import col_pkg::*;
#(
    parameter int N_SP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SP:0]     tok_vec,
    input logic [N_SP-1:0]   drv_vec,
    input logic [BUS_W-1:0]  bus_data,
    input logic              bus_valid
);
    // R6: one owner of the bus at a time
    a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_vec));

    // R11: idle bus reads zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> bus_data == '0);

    for (genvar s = 0; s < N_SP; s++) begin : g_chk
        // R3: packet opens with the owner's header
        a_r3_header: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_vec[s]) |-> bus_data == BUS_W'(s));

        // R6: last byte of a packet coincides with token hand-off
        a_r6_handoff: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drv_vec[s]) |-> $past(tok_vec[s+1]));
    end
endmodule

bind col_token_readout col_token_readout_chk #(.N_SP(N_SP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_vec   (tok_vec),
    .drv_vec   (drv_vec),
    .bus_data  (bus_data),
    .bus_valid (bus_valid)
);

// File: tb/col_token_readout_test.sv
module col_token_readout_test;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            col_start = 1'b0;
    logic [N*16-1:0] pix_hit = '0;
    logic [N*64-1:0] pix_tot = '0;
    logic [7:0]      bus_data;
    logic            bus_valid;
    logic            col_end;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0]  exp_q[$];
    logic [15:0] m_mask [N];
    logic [63:0] m_tot  [N];
    bit          done = 0;

    col_token_readout #(.N_SP(N)) uut (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] tots(input int seed);
        logic [63:0] t;
        for (int i = 0; i < 16; i++) t[i*4 +: 4] = 4'(seed + i*5);
        return t;
    endfunction

    task automatic model_hit(input int s, input logic [15:0] m, input logic [63:0] t);
        for (int i = 0; i < 16; i++) begin
            if (m[i] && !m_mask[s][i]) begin
                m_mask[s][i] = 1'b1;
                m_tot[s][i*4 +: 4] = t[i*4 +: 4];
            end
        end
    endtask

    task automatic put_hits(input int s, input logic [15:0] m, input logic [63:0] t);
        @(posedge clk); #1;
        pix_hit[s*16 +: 16] = m;
        pix_tot[s*64 +: 64] = t;
        model_hit(s, m, t);
        @(posedge clk); #1;
        pix_hit = '0;
    endtask

    // Monitor: compare every strobed byte with the scoreboard (R3,R4,R5,R11)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (bus_valid) begin
                    if (exp_q.size() == 0) check("R6 unexpected byte", 32'(bus_data), 32'hFFFF);
                    else check("R3/R4/R5 packet byte", 32'(bus_data), 32'(exp_q.pop_front()));
                end else begin
                    check("R11 idle bus", 32'(bus_data), 0);
                end
                if (col_end) check("R7 bytes left at col_end", exp_q.size(), 0);
            end
        end
    end

    // One scan; optionally inject hits into super-pixel 0 at cycle inj_at (R9)
    task automatic scan(input string req, input int inj_at, input logic [15:0] inj_m, input logic [63:0] inj_t);
        int b = 0;
        int end_cyc = -1;
        logic [7:0] hi;
        bit odd;
        for (int s = 0; s < N; s++) begin
            if (m_mask[s] != 0) begin
                exp_q.push_back(8'(s));
                exp_q.push_back(m_mask[s][15:8]);
                exp_q.push_back(m_mask[s][7:0]);
                b += 3;
                odd = 0;
                for (int i = 0; i < 16; i++) begin
                    if (m_mask[s][i]) begin
                        if (!odd) begin hi = {m_tot[s][i*4 +: 4], 4'h0}; odd = 1; end
                        else begin exp_q.push_back(hi | 8'(m_tot[s][i*4 +: 4])); b++; odd = 0; end
                    end
                end
                if (odd) begin exp_q.push_back(hi); b++; end
            end
            m_mask[s] = '0;
        end
        if (inj_at >= 0) model_hit(0, inj_m, inj_t);
        for (int cyc = 0; cyc < 200 && end_cyc < 0; cyc++) begin
            @(posedge clk); #1;
            col_start = (cyc == 0);
            if (cyc == inj_at) begin pix_hit[15:0] = inj_m; pix_tot[63:0] = inj_t; end
            else pix_hit = '0;
            @(negedge clk);
            if (cyc == 0) check("R12 no byte in token cycle", 32'(bus_valid), 0);
            if (cyc == 1 && b > 0) check("R12 header one cycle after token", 32'(bus_valid), 1);
            if (col_end) end_cyc = cyc;
        end
        @(posedge clk); #1;
        col_start = 0; pix_hit = '0;
        @(negedge clk);
        check({req, " / R7 single col_end pulse"}, 32'(col_end), 0);
        check({req, " / R7 end cycle"}, 32'(end_cyc), 32'(b));
    endtask

    initial begin
        for (int s = 0; s < N; s++) begin m_mask[s] = '0; m_tot[s] = '0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 bus_valid in reset", 32'(bus_valid), 0);
        check("R1 bus_data in reset", 32'(bus_data), 0);
        check("R1 col_end in reset", 32'(col_end), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bus_valid after reset", 32'(bus_valid), 0);

        scan("R2 empty column", -1, '0, '0);

        // single hit, odd count padding
        put_hits(1, 16'h0020, tots(4));
        scan("R3 R4 R5 single hit", -1, '0, '0);

        // several super-pixels, full map, gap at SP1
        put_hits(0, 16'h8001, tots(1));
        put_hits(2, 16'hFFFF, tots(7));
        put_hits(3, 16'h0007, tots(11));
        scan("R6 multi super-pixel", -1, '0, '0);

        // R8: nothing left after readout
        scan("R8 cleared after readout", -1, '0, '0);

        // R10: second hit on same pixel ignored
        put_hits(0, 16'h0008, tots(2));
        put_hits(0, 16'h0018, tots(9));
        scan("R10 first hit kept", -1, '0, '0);

        // R9: hit in token cycle is held for next turn
        put_hits(0, 16'h0102, tots(3));
        scan("R9 hit at token cycle", 0, 16'h0401, tots(6));
        scan("R9 held hit sent next turn", -1, '0, '0);

        // R9: hit during readout held
        put_hits(0, 16'hA5A5, tots(13));
        put_hits(3, 16'h8000, tots(5));
        scan("R9 hit during readout", 2, 16'h0240, tots(8));
        scan("R9 held hit sent next turn", -1, '0, '0);
        scan("R8 R2 empty after all", -1, '0, '0);

        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule